// File: doc/BRIEF.md
# Three-Master Selectable-Priority Bus Arbiter

This block shares one bus among three masters: an Ethernet controller, a DMA engine and the CPU. Each master drives one bit of a request vector and receives one bit of a registered grant vector. The arbiter only re-decides ownership at an arbitration point, the clock edge where the bus-cycle-done strobe is high. The grant then changes on that edge and is visible in the following cycle.

Two fixed priority orders are available, mirror images of each other, chosen by a select input. A second input, the owner-hold mode, makes the current owner compete in the next arbitration as though it were requesting. If, in that mode, the idle owner outranks every live requester, the bus is left ungranted for exactly one clock. The arbiter then hands it to the best live requester sampled at the end of that clock. With no requests in the ordinary mode the bus parks on the CPU.

Top module: `bus_arb3`

## Requirements
- R1: After synchronous reset the grant vector is 3'b100 (CPU only). Bit positions: bit 0 Ethernet, bit 1 DMA, bit 2 CPU.
- R2: The grant vector never has more than one bit set; it is all-zero only during a dead cycle.
- R3: While `bus_done` is low and the grant is non-zero, the grant keeps its value on the next edge.
- R4: With `prio_cpu_first` = 0 the ranking is Ethernet, then DMA, then CPU.
- R5: With `prio_cpu_first` = 1 the ranking is CPU, then DMA, then Ethernet.
- R6: With `hold_owner` = 0 and no request at an arbitration point, the grant becomes (or stays) CPU.
- R7: With `hold_owner` = 0 the owner only keeps the bus if its own live request wins; it loses the bus to a higher live requester, and also when it has dropped its request and another master requests.
- R8: With `hold_owner` = 1, if the owner is not requesting but outranks all live requesters, the grant goes to zero for exactly one clock. It then goes to the highest live requester sampled in that dead clock, or CPU if there is none. A `bus_done` pulse during the dead clock is ignored.
- R9: With `hold_owner` = 1 and no other master requesting, the owner keeps the grant at an arbitration point whether or not it requests.
- R10: With `hold_owner` = 1 and a live requester that outranks the owner, the grant moves to that requester with no dead cycle.
- R11: A change of `prio_cpu_first` while `bus_done` is low does not move the grant; the new order applies at the next arbitration point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 3 | Requests: bit 0 Ethernet, bit 1 DMA, bit 2 CPU |
| bus_done | input | 1 | Current bus cycle ends at this edge (arbitration point) |
| prio_cpu_first | input | 1 | 0: Ethernet>DMA>CPU, 1: CPU>DMA>Ethernet |
| hold_owner | input | 1 | 1: current owner competes as if requesting |
| grant | output | 3 | Registered one-hot grant, zero only in a dead cycle |

## Verification
A wrong phase bit shows up as a grant vector stuck at zero, or as a grant that moves without a `bus_done` pulse. Either is visible one clock after the faulty edge. A wrong ranking or a wrong candidate set shows up as the wrong one-hot grant in the cycle right after the arbitration point. The bench therefore compares the grant in every cycle, with stimulus built so that each ordering, the parking case and the dead cycle each produce a distinct grant value.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // Arbiter phase: normal ownership or the single idle clock.
  typedef enum logic {
    PH_OWNED = 1'b0,
    PH_DEAD  = 1'b1
  } arb_phase_e;
endpackage

// File: rtl/arb_pick.sv
// Fixed-priority one-hot picker. low index wins when high_first = 0,
// high index wins when high_first = 1.
module arb_pick #(
  parameter int N_MASTERS = 3
) (
  input  logic [N_MASTERS-1:0] vec,
  input  logic                 high_first,
  output logic [N_MASTERS-1:0] win
);
  logic [N_MASTERS-1:0] win_lo;
  logic [N_MASTERS-1:0] win_hi;

  genvar g;
  generate
    for (g = 0; g < N_MASTERS; g++) begin : g_rank
      if (g == 0) begin : g_first
        assign win_lo[g] = vec[g];
      end else begin : g_rest
        assign win_lo[g] = vec[g] & ~(|vec[g-1:0]);
      end
      if (g == N_MASTERS-1) begin : g_top
        assign win_hi[g] = vec[g];
      end else begin : g_below
        assign win_hi[g] = vec[g] & ~(|vec[N_MASTERS-1:g+1]);
      end
    end
  endgenerate

  assign win = high_first ? win_hi : win_lo;
endmodule

// File: rtl/arb_decide.sv
// Combinational decision taken at an arbitration point.
module arb_decide #(
  parameter int N_MASTERS = 3,
  parameter int PARK_IDX  = N_MASTERS - 1
) (
  input  logic [N_MASTERS-1:0] req,
  input  logic [N_MASTERS-1:0] owner,
  input  logic                 prio_sel,
  input  logic                 hold,
  output logic [N_MASTERS-1:0] next_grant,
  output logic [N_MASTERS-1:0] live_grant,
  output logic                 go_dead
);
  localparam logic [N_MASTERS-1:0] PARK = N_MASTERS'(1) << PARK_IDX;

  logic [N_MASTERS-1:0] cand;
  logic [N_MASTERS-1:0] live_win;
  logic [N_MASTERS-1:0] cand_win;
  logic                 owner_idle;
  logic                 others_req;

  assign cand = hold ? (req | owner) : req;

  arb_pick #(.N_MASTERS(N_MASTERS)) u_live (
    .vec(req), .high_first(prio_sel), .win(live_win)
  );
  arb_pick #(.N_MASTERS(N_MASTERS)) u_cand (
    .vec(cand), .high_first(prio_sel), .win(cand_win)
  );

  assign owner_idle = ~(|(req & owner));
  assign others_req = |(req & ~owner);
  assign live_grant = (|req) ? live_win : PARK;

  always_comb begin
    go_dead    = 1'b0;
    next_grant = live_grant;
    if (hold) begin
      if ((cand_win == owner) && owner_idle && others_req) begin
        go_dead    = 1'b1;
        next_grant = '0;
      end else if (|cand) begin
        next_grant = cand_win;
      end
    end
  end
endmodule

// File: rtl/bus_arb3.sv
module bus_arb3 #(
  parameter int N_MASTERS = 3,
  parameter int PARK_IDX  = N_MASTERS - 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_MASTERS-1:0] req,
  input  logic                 bus_done,
  input  logic                 prio_cpu_first,
  input  logic                 hold_owner,
  output logic [N_MASTERS-1:0] grant
);
  import arb_pkg::*;

  localparam logic [N_MASTERS-1:0] PARK = N_MASTERS'(1) << PARK_IDX;

  arb_phase_e           phase_q;
  logic [N_MASTERS-1:0] grant_q;
  logic [N_MASTERS-1:0] next_grant;
  logic [N_MASTERS-1:0] live_grant;
  logic                 go_dead;

  arb_decide #(.N_MASTERS(N_MASTERS), .PARK_IDX(PARK_IDX)) u_decide (
    .req        (req),
    .owner      (grant_q),
    .prio_sel   (prio_cpu_first),
    .hold       (hold_owner),
    .next_grant (next_grant),
    .live_grant (live_grant),
    .go_dead    (go_dead)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_OWNED;
      grant_q <= PARK;
    end else if (phase_q == PH_DEAD) begin
      phase_q <= PH_OWNED;
      grant_q <= live_grant;
    end else if (bus_done) begin
      phase_q <= go_dead ? PH_DEAD : PH_OWNED;
      grant_q <= next_grant;
    end
  end

  assign grant = grant_q;
endmodule

// File: rtl/bus_arb3_chk.sv
module bus_arb3_chk #(
  parameter int N_MASTERS = 3,
  parameter int PARK_IDX  = N_MASTERS - 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic [N_MASTERS-1:0] req,
  input logic                 bus_done,
  input logic                 prio_cpu_first,
  input logic                 hold_owner,
  input logic [N_MASTERS-1:0] grant
);
  localparam logic [N_MASTERS-1:0] PARK = N_MASTERS'(1) << PARK_IDX;

  p_onehot_grant_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  p_hold_between_points_r3: assert property (@(posedge clk) disable iff (rst)
    (!bus_done && grant != '0) |=> $stable(grant));

  p_dead_one_clock_r8: assert property (@(posedge clk) disable iff (rst)
    (grant == '0) |=> (grant != '0));

  p_park_cpu_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_done && grant != '0 && !hold_owner && req == '0) |=> (grant == PARK));

  p_low_order_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_done && grant != '0 && !hold_owner && !prio_cpu_first && req[0])
      |=> (grant == N_MASTERS'(1)));

  p_high_order_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_done && grant != '0 && !hold_owner && prio_cpu_first && req[N_MASTERS-1])
      |=> (grant == PARK));
endmodule

bind bus_arb3 bus_arb3_chk #(.N_MASTERS(N_MASTERS), .PARK_IDX(PARK_IDX)) u_chk (
  .clk(clk), .rst(rst), .req(req), .bus_done(bus_done),
  .prio_cpu_first(prio_cpu_first), .hold_owner(hold_owner), .grant(grant)
);

// File: tb/bus_arb3_bench.sv
module bus_arb3_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] req = '0;
  logic       bus_done = 1'b0;
  logic       prio_cpu_first = 1'b0;
  logic       hold_owner = 1'b0;
  logic [2:0] grant;

  typedef struct {
    logic [2:0] exp;
    string      tag;
  } exp_item_t;

  exp_item_t sb_q[$];
  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bus_arb3 u_bus_arb3 (
    .clk(clk), .rst(rst), .req(req), .bus_done(bus_done),
    .prio_cpu_first(prio_cpu_first), .hold_owner(hold_owner), .grant(grant)
  );

  // Driver: one cycle of stimulus plus the grant expected after the edge.
  task automatic step(input logic [2:0] r, input logic d, input logic p,
                      input logic h, input logic [2:0] e, input string tag);
    exp_item_t it;
    @(negedge clk);
    req = r; bus_done = d; prio_cpu_first = p; hold_owner = h;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: samples 2 ns after each rising edge.
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      exp_item_t it;
      it = sb_q.pop_front();
      n_checks++;
      if (grant !== it.exp) begin
        n_fail++;
        $display("FAIL %s: grant=%b expected=%b", it.tag, grant, it.exp);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // req bits: 0 Ethernet, 1 DMA, 2 CPU
    step(3'b000, 0, 0, 0, 3'b100, "R1 reset parks CPU");
    step(3'b011, 0, 0, 0, 3'b100, "R3 no strobe no move");
    step(3'b011, 1, 0, 0, 3'b001, "R4 Ethernet over DMA");
    step(3'b110, 0, 0, 0, 3'b001, "R3 hold until strobe");
    step(3'b110, 1, 0, 0, 3'b010, "R4 R7 DMA over CPU, idle owner released");
    step(3'b111, 1, 1, 0, 3'b100, "R5 CPU first");
    step(3'b011, 1, 1, 0, 3'b010, "R5 R7 DMA over Ethernet");
    step(3'b001, 1, 1, 0, 3'b001, "R5 Ethernet alone");
    step(3'b000, 1, 0, 0, 3'b100, "R6 park on CPU");
    step(3'b000, 1, 0, 0, 3'b100, "R6 stay parked");
    step(3'b011, 0, 1, 0, 3'b100, "R11 request without strobe");
    step(3'b011, 0, 0, 0, 3'b100, "R11 order change mid cycle");
    step(3'b011, 1, 0, 0, 3'b001, "R11 new order at strobe");
    step(3'b000, 1, 0, 1, 3'b001, "R9 idle owner keeps bus");
    step(3'b110, 1, 0, 1, 3'b000, "R8 dead cycle");
    step(3'b110, 1, 0, 1, 3'b010, "R8 strobe ignored, DMA after dead");
    step(3'b001, 1, 0, 1, 3'b001, "R10 higher requester direct");
    step(3'b001, 1, 0, 1, 3'b001, "R9 requesting owner keeps");
    step(3'b100, 1, 0, 1, 3'b000, "R8 dead before CPU");
    step(3'b100, 0, 0, 1, 3'b100, "R8 CPU after dead");
    step(3'b011, 1, 1, 1, 3'b000, "R8 dead with CPU first");
    step(3'b001, 0, 1, 1, 3'b001, "R8 resampled live request");
    step(3'b101, 1, 1, 1, 3'b100, "R10 CPU outranks owner");
    step(3'b000, 1, 1, 0, 3'b100, "R6 R2 park after release");
    step(3'b000, 0, 0, 0, 3'b100, "R2 stable grant");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: finished=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule